// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block holds the timing state of every bank in one DRAM channel and turns each access request into a command schedule. For each bank it keeps the row that is open, if any, and three earliest-allowed times: one for the next column command, one for precharge and one for activate. The channel also keeps one shared time after which the data bus is free. All times are counts of a free-running cycle counter that the block owns and exposes.

A request names a bank, a row, a read or write direction, and whether the row should be closed after the access. In the cycle after the request, the block reports four things. It says whether the access hit the open row. It gives the time of any precharge and the time of any activate. It gives the column command time and the time the data burst finishes on the bus. It also updates the bank's stored state, and the activate spacing of the other banks in the same rank. An outside scheduler chooses which request to present. This block only computes the timing and keeps the state.

Top module: `dbt_bank_tracker`

## Requirements
- R1: While reset is high, every bank is closed, every stored earliest time and the bus-free time become 0, the time counter is 0 and resp_valid is 0.
- R2: An access to the row already open in its bank reports resp_hit=1, no precharge and no activate. Its column command time is the larger of the bank's earliest column time and the request time, before bus alignment.
- R3: An access to a bank that has a different row open reports resp_pre=1. The precharge time is the larger of the bank's earliest precharge time and the request time. The bank's earliest activate time then rises to at least precharge time + T_RP. An access to a closed bank reports resp_pre=0.
- R4: On a miss, the activate time is the larger of the bank's earliest activate time and the request time. The bank's earliest precharge time becomes activate time + T_RAS. The column command time before bus alignment is activate time + T_RCD.
- R5: The column command time is never below bus-free time − T_CL (0 if that is negative). Ready time = command time + T_CL + T_BURST, and the bus-free time becomes the ready time.
- R6: After a column command, the bank's earliest column time becomes command time + T_BURST.
- R7: After a write, the bank's earliest precharge time becomes at least ready time + T_WR.
- R8: An activate at time A raises the earliest activate time of every bank in the same rank to at least A + T_RRD. Bank index / BANKS_PER_RANK gives the rank. Banks in other ranks are unaffected.
- R9: With req_autopre=1, the bank is closed after the access. It is precharged at the larger of the request time and its earliest precharge time. Its earliest activate time rises to at least that time + T_RP, so the next access to any row of it is a miss with resp_pre=0.
- R10: The time counter `now` rises by exactly 1 on every clock edge outside reset.
- R11: Results appear on the response ports one cycle after req_valid is sampled high. resp_valid is high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_bank | input | BANK_W | Target bank index |
| req_row | input | ROW_W | Target row |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| now | output | TICK_W | Current time in cycles |
| resp_valid | output | 1 | Response fields valid |
| resp_hit | output | 1 | Access hit the open row |
| resp_pre | output | 1 | A precharge was needed |
| resp_pre_at | output | TICK_W | Precharge time (valid when resp_pre) |
| resp_act_at | output | TICK_W | Activate time (valid when !resp_hit) |
| resp_cmd_at | output | TICK_W | Column command time |
| resp_ready_at | output | TICK_W | Time the data burst finishes |

## Verification
A corrupted stored row shows up at the next access to that bank, as a wrong resp_hit or resp_pre flag in the following cycle. A stale or wrong earliest time stays hidden until a later request to the same bank, or to a bank in the same rank, reaches the limit it sets. It then shows as a shifted precharge, activate or command time. The bus-free time reaches every bank, so an error in it shifts the very next command time on any bank. The bench therefore mixes banks, rows, directions, auto-precharge and idle gaps. This lets every stored value gate a later result within a few requests.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    localparam int TICK_W = 20;
    localparam int ROW_W  = 8;

    typedef logic [TICK_W-1:0] tick_t;
    typedef logic [ROW_W-1:0]  row_t;

    // stored per-bank timing state
    typedef struct packed {
        logic  open;
        row_t  row;
        tick_t col_ok;
        tick_t pre_ok;
        tick_t act_ok;
    } bank_state_t;

    // result of one access
    typedef struct packed {
        logic  hit;
        logic  pre;
        tick_t pre_at;
        tick_t act_at;
        tick_t cmd_at;
        tick_t ready_at;
    } access_res_t;

    function automatic tick_t tmax(input tick_t a, input tick_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbt_clock.sv
module dbt_clock
    import dbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output tick_t now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + tick_t'(1);
    end
endmodule

// File: rtl/dbt_access_calc.sv
module dbt_access_calc
    import dbt_pkg::*;
#(
    parameter int T_RAS   = 8,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_CL    = 4,
    parameter int T_BURST = 2,
    parameter int T_WR    = 3,
    parameter int T_RRD   = 2
) (
    input  bank_state_t cur,
    input  row_t        row,
    input  logic        is_write,
    input  logic        autopre,
    input  tick_t       now,
    input  tick_t       bus_free,
    output bank_state_t nxt,
    output access_res_t res
);
    localparam tick_t RAS   = tick_t'(T_RAS);
    localparam tick_t RCD   = tick_t'(T_RCD);
    localparam tick_t RP    = tick_t'(T_RP);
    localparam tick_t CL    = tick_t'(T_CL);
    localparam tick_t BURST = tick_t'(T_BURST);
    localparam tick_t WR    = tick_t'(T_WR);
    localparam tick_t RRD   = tick_t'(T_RRD);

    logic  hit, need_pre;
    tick_t pre_t, act_floor, act_t, col_base, bus_floor, cmd_t, ready_t;
    tick_t pre_base, pre_fin, act_base, ap_t;

    always_comb begin
        hit       = cur.open && (cur.row == row);
        need_pre  = cur.open && !hit;
        pre_t     = tmax(cur.pre_ok, now);
        act_floor = need_pre ? tmax(cur.act_ok, pre_t + RP) : cur.act_ok;
        act_t     = tmax(act_floor, now);
        col_base  = hit ? tmax(cur.col_ok, now) : act_t + RCD;
        bus_floor = (bus_free > CL) ? bus_free - CL : '0;
        cmd_t     = tmax(col_base, bus_floor);
        ready_t   = cmd_t + CL + BURST;

        pre_base  = hit ? cur.pre_ok : act_t + RAS;
        pre_fin   = is_write ? tmax(pre_base, ready_t + WR) : pre_base;
        act_base  = hit ? cur.act_ok : tmax(act_floor, act_t + RRD);
        ap_t      = tmax(now, pre_fin);

        nxt.open   = !autopre;
        nxt.row    = row;
        nxt.col_ok = cmd_t + BURST;
        nxt.pre_ok = pre_fin;
        nxt.act_ok = autopre ? tmax(act_base, ap_t + RP) : act_base;

        res.hit      = hit;
        res.pre      = need_pre;
        res.pre_at   = need_pre ? pre_t : '0;
        res.act_at   = hit ? '0 : act_t;
        res.cmd_at   = cmd_t;
        res.ready_at = ready_t;
    end
endmodule

// File: rtl/dbt_bank_slot.sv
module dbt_bank_slot
    import dbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  bank_state_t wr_state,
    input  logic        rrd_en,
    input  tick_t       rrd_at,
    output bank_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (wr_en) begin
            state <= wr_state;
        end else if (rrd_en) begin
            state.act_ok <= tmax(state.act_ok, rrd_at);
        end
    end
endmodule

// File: rtl/dbt_bank_tracker.sv
module dbt_bank_tracker
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int BANKS_PER_RANK = 2,
    parameter int T_RAS          = 8,
    parameter int T_RCD          = 3,
    parameter int T_RP           = 3,
    parameter int T_CL           = 4,
    parameter int T_BURST        = 2,
    parameter int T_WR           = 3,
    parameter int T_RRD          = 2,
    localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              req_autopre,
    output logic [TICK_W-1:0] now,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_pre,
    output logic [TICK_W-1:0] resp_pre_at,
    output logic [TICK_W-1:0] resp_act_at,
    output logic [TICK_W-1:0] resp_cmd_at,
    output logic [TICK_W-1:0] resp_ready_at
);
    bank_state_t banks [NUM_BANKS];
    bank_state_t cur_state, nxt_state;
    access_res_t res, res_q;
    tick_t       bus_free;
    logic        valid_q;

    dbt_clock u_clock (.clk(clk), .rst(rst), .now(now));

    assign cur_state = banks[req_bank];

    dbt_access_calc #(
        .T_RAS(T_RAS), .T_RCD(T_RCD), .T_RP(T_RP), .T_CL(T_CL),
        .T_BURST(T_BURST), .T_WR(T_WR), .T_RRD(T_RRD)
    ) u_calc (
        .cur(cur_state), .row(req_row), .is_write(req_write),
        .autopre(req_autopre), .now(now), .bus_free(bus_free),
        .nxt(nxt_state), .res(res)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel, same_rank;
        assign sel       = req_valid && (req_bank == BANK_W'(b));
        assign same_rank = (int'(req_bank) / BANKS_PER_RANK) == (b / BANKS_PER_RANK);
        dbt_bank_slot u_slot (
            .clk(clk), .rst(rst),
            .wr_en(sel), .wr_state(nxt_state),
            .rrd_en(req_valid && !res.hit && same_rank),
            .rrd_at(res.act_at + tick_t'(T_RRD)),
            .state(banks[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_free <= '0;
            valid_q  <= 1'b0;
            res_q    <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                bus_free <= res.ready_at;
                res_q    <= res;
            end
        end
    end

    assign resp_valid    = valid_q;
    assign resp_hit      = res_q.hit;
    assign resp_pre      = res_q.pre;
    assign resp_pre_at   = res_q.pre_at;
    assign resp_act_at   = res_q.act_at;
    assign resp_cmd_at   = res_q.cmd_at;
    assign resp_ready_at = res_q.ready_at;
endmodule

// File: rtl/dbt_bank_tracker_chk.sv
module dbt_bank_tracker_chk
    import dbt_pkg::*;
#(
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_BURST = 2
) (
    input logic  clk,
    input logic  rst,
    input logic  req_valid,
    input tick_t now,
    input logic  resp_valid,
    input logic  resp_hit,
    input logic  resp_pre,
    input tick_t resp_pre_at,
    input tick_t resp_act_at,
    input tick_t resp_cmd_at,
    input tick_t resp_ready_at
);
    tick_t last_ready;
    logic  seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ready <= '0;
            seen       <= 1'b0;
        end else if (resp_valid) begin
            last_ready <= resp_ready_at;
            seen       <= 1'b1;
        end
    end

    a_r10_time_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> now == $past(now) + tick_t'(1));

    a_r11_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    a_r5_bus_gap: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && seen) |-> resp_ready_at >= last_ready + tick_t'(T_BURST));

    a_r2_hit_no_pre: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> !resp_pre);

    a_r4_act_before_cmd: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> resp_cmd_at >= resp_act_at + tick_t'(T_RCD));

    a_r3_pre_before_act: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_pre) |-> resp_act_at >= resp_pre_at + tick_t'(T_RP));

    a_r2_cmd_not_past: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_cmd_at + tick_t'(1) >= now);
endmodule

bind dbt_bank_tracker dbt_bank_tracker_chk #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_BURST(T_BURST)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .now(now),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pre(resp_pre),
    .resp_pre_at(resp_pre_at), .resp_act_at(resp_act_at),
    .resp_cmd_at(resp_cmd_at), .resp_ready_at(resp_ready_at)
);

// File: tb/dbt_bank_tracker_tb.sv
module dbt_bank_tracker_tb;
    import dbt_pkg::*;

    localparam int CLK_P = 10;
    localparam int NB = 4, BPR = 2;
    localparam int RAS = 8, RCD = 3, RP = 3, CL = 4, BUR = 2, WRT = 3, RRD = 2;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_autopre = 0;
    logic [1:0] req_bank = 0;
    logic [ROW_W-1:0] req_row = 0;
    logic [TICK_W-1:0] now, resp_pre_at, resp_act_at, resp_cmd_at, resp_ready_at;
    logic resp_valid, resp_hit, resp_pre;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    dbt_bank_tracker #(
        .NUM_BANKS(NB), .BANKS_PER_RANK(BPR), .T_RAS(RAS), .T_RCD(RCD),
        .T_RP(RP), .T_CL(CL), .T_BURST(BUR), .T_WR(WRT), .T_RRD(RRD)
    ) u_dut (.*);

    // arithmetic model of the requirements
    bit m_open [NB];
    int m_row [NB], m_col [NB], m_pre [NB], m_act [NB];
    int m_bus;
    bit e_hit, e_pre;
    int e_pre_at, e_act_at, e_cmd, e_ready;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 0; m_row[i] = 0; m_col[i] = 0; m_pre[i] = 0; m_act[i] = 0;
        end
        m_bus = 0;
    endtask

    task automatic model_access(input int b, input int r, input bit w, input bit ap, input int t);
        int act_floor, pb, ab, apt;
        e_hit = m_open[b] && m_row[b] == r;
        e_pre = m_open[b] && !e_hit;
        e_pre_at = e_pre ? mx(m_pre[b], t) : 0;
        act_floor = e_pre ? mx(m_act[b], e_pre_at + RP) : m_act[b];
        e_act_at = e_hit ? 0 : mx(act_floor, t);
        e_cmd = e_hit ? mx(m_col[b], t) : e_act_at + RCD;
        e_cmd = mx(e_cmd, mx(m_bus - CL, 0));
        e_ready = e_cmd + CL + BUR;
        pb = e_hit ? m_pre[b] : e_act_at + RAS;
        if (w) pb = mx(pb, e_ready + WRT);
        ab = e_hit ? m_act[b] : act_floor;
        if (!e_hit)
            for (int k = 0; k < NB; k++)
                if (k / BPR == b / BPR) begin
                    if (k == b) ab = mx(ab, e_act_at + RRD);
                    else m_act[k] = mx(m_act[k], e_act_at + RRD);
                end
        apt = mx(t, pb);
        m_open[b] = !ap; m_row[b] = r; m_col[b] = e_cmd + BUR;
        m_pre[b] = pb;
        m_act[b] = ap ? mx(ab, apt + RP) : ab;
        m_bus = e_ready;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // at a negedge: issue one request, check its response one cycle later
    task automatic access(input int b, input int r, input bit w, input bit ap);
        int t;
        t = int'(now);
        req_valid = 1; req_bank = 2'(b); req_row = ROW_W'(r);
        req_write = w; req_autopre = ap;
        model_access(b, r, w, ap, t);
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        check("R11 resp_valid", int'(resp_valid), 1);
        check("R2 hit flag", int'(resp_hit), int'(e_hit));
        check("R3/R9 pre flag", int'(resp_pre), int'(e_pre));
        if (e_pre) check("R3/R7 pre_at", int'(resp_pre_at), e_pre_at);
        if (!e_hit) check("R4/R8/R9 act_at", int'(resp_act_at), e_act_at);
        check("R5/R6 cmd_at", int'(resp_cmd_at), e_cmd);
        check("R5 ready_at", int'(resp_ready_at), e_ready);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; req_valid = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        int t0;
        do_reset();
        // R1 / R10 reset state
        check("R1 now after reset", int'(now), 0);
        check("R1 resp_valid", int'(resp_valid), 0);
        @(posedge clk); @(negedge clk);
        check("R10 now step", int'(now), 1);

        // directed: write recovery, same-rank spacing, auto-precharge
        t0 = int'(now);
        access(0, 5, 1, 0);
        check("R4 first act", int'(resp_act_at), t0);
        check("R4 first cmd", int'(resp_cmd_at), t0 + 3);
        access(1, 5, 0, 0);
        check("R8 same rank act", int'(resp_act_at), t0 + 2);
        access(0, 6, 0, 0);
        check("R7 pre after write", int'(resp_pre_at), t0 + 12);
        check("R3 act after pre", int'(resp_act_at), t0 + 15);
        access(2, 1, 0, 1);
        check("R8 other rank act", int'(resp_act_at), t0 + 3);
        access(2, 1, 0, 0);
        check("R9 closed miss hit", int'(resp_hit), 0);
        check("R9 closed no pre", int'(resp_pre), 0);
        check("R9 act after autopre", int'(resp_act_at), t0 + 14);
        access(2, 1, 0, 0);
        check("R2 reopened hit", int'(resp_hit), 1);

        // R1: reset clears open rows
        do_reset();
        t0 = int'(now);
        access(2, 1, 0, 0);
        check("R1 closed after reset", int'(resp_pre), 0);
        check("R1 act at request", int'(resp_act_at), t0);

        // sweep: banks, rows, direction, auto-precharge, idle gaps
        for (int i = 0; i < 192; i++) begin
            int gap;
            gap = (i / 48 == 0) ? 0 : (i / 48 == 1) ? 1 : (i / 48 == 2) ? 3 : 6;
            access(i % 4, (i / 8) % 3, bit'((i / 2) % 2), bit'((i / 24) % 2));
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); @(negedge clk);
                check("R11 idle resp_valid", int'(resp_valid), 0);
            end
        end
        t0 = int'(now);
        @(posedge clk); @(negedge clk);
        check("R10 now step late", int'(now), t0 + 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule